// File: doc/BRIEF.md
# Audio Codec Control Register File

This block is the control register file of an audio codec. A simple register bus reaches it. The bus carries a 7-bit word index, a 16-bit write word, a write strobe, a read strobe and a registered 16-bit read word. Software uses it to identify the codec, to set the stereo output attenuation and mute, and to keep a bank of general settings. Blocks further along the chip use those settings.

Index 00h is a fixed identification word. Writing any value to it acts as a register reset: in the cycle after the write, every register in both reset windows returns to its default. Index 02h holds the mute flag and two 6-bit attenuation codes, one per channel. The codes count 1.5 dB steps from 0 dB at code 0 to -46.5 dB at code 31. A written code with bit 5 set saturates to 31, and the register stores it that way. The other even indices in the two windows are plain read/write words. Every other index is a hole.

Top module: `codec_ctrl_regs`

## Requirements
- R1: After the synchronous active-low reset, index 02h reads 8000h, `mute_o` is 1 and both attenuation outputs are 0. Every bank register reads 0000h.
- R2: A read of index 00h always returns 25ADh. Bit 15 is 0, D14:D10 hold the enhancement ID 01001, bit 9 is 0, and capability bits D8, D7, D5, D3, D2 and D0 are 1.
- R3: A write of any data to index 00h does not change what index 00h reads. From the next clock edge on, index 02h reads 8000h and every register at the even indices 04h–3Ah and 5Ah–7Ah reads 0000h.
- R4: Index 02h layout: D15 is mute, D13:D8 is the left code and D5:D0 is the right code. D14, D7 and D6 always read 0. `mute_o`, `atten_l_o` and `atten_r_o` show the stored fields.
- R5: When bit 5 of a written attenuation field is 1, that field is stored and read back as 011111, whatever its lower bits were.
- R6: When bit 5 of a written attenuation field is 0 (codes 000000 to 011111), that field is stored unchanged.
- R7: The even indices 04h–3Ah and 5Ah–7Ah each hold an independent 16-bit read/write word.
- R8: A write to an odd index changes no register, and a read from an odd index returns 0000h.
- R9: A write to an even index outside both windows (3Ch–58h, 7Ch–7Eh) changes no register, and a read from such an index returns 0000h.
- R10: Read data appears on `rd_data` at the clock edge that samples `rd_en`. `rd_data` holds its value while `rd_en` is low.
- R11: When a read and a write to the same index fall in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_idx | input | 7 | Register index for the current access |
| wr_data | input | 16 | Write word |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read word |
| mute_o | output | 1 | Stored mute flag |
| atten_l_o | output | 6 | Stored left attenuation code |
| atten_r_o | output | 6 | Stored right attenuation code |

## Verification
The assertions assume that `reg_idx` and `wr_data` are stable and defined whenever a strobe is high. They also assume that a strobe is taken as one access per cycle, so each write and read lands at the sampling edge. The bench drives every input on the falling edge and raises each strobe for exactly one cycle, so each access happens at one known rising edge. The bench reads results at the following falling edge, after the registered read path and the storage have both updated.

// File: rtl/codec_regs_pkg.sv
// Package: shared constants and helpers for the codec control register file.
// Assumes word indices are even; window bounds are inclusive and even.
package codec_regs_pkg;
    localparam int IDX_W   = 7;
    localparam int DATA_W  = 16;
    localparam int CODE_W  = 6;

    localparam logic [IDX_W-1:0] IDX_IDENT = 7'h00;
    localparam logic [IDX_W-1:0] IDX_VOL   = 7'h02;

    // reset windows (inclusive, even)
    localparam int WIN_A_LO = 'h00;
    localparam int WIN_A_HI = 'h3A;
    localparam int WIN_B_LO = 'h5A;
    localparam int WIN_B_HI = 'h7A;

    // window A loses the identification word and the volume word to the bank
    localparam int BANK_A_CNT = (WIN_A_HI - WIN_A_LO) / 2 + 1 - 2;
    localparam int BANK_B_CNT = (WIN_B_HI - WIN_B_LO) / 2 + 1;
    localparam int BANK_CNT   = BANK_A_CNT + BANK_B_CNT;
    localparam int SLOT_W     = $clog2(BANK_CNT);

    // identification word fields
    localparam logic [4:0] ENH_ID = 5'b01001;
    localparam logic [DATA_W-1:0] IDENT_WORD =
        {1'b0, ENH_ID, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

    localparam logic [DATA_W-1:0] VOL_DEFAULT = 16'h8000;

    // Bus index owned by bank slot j.
    function automatic logic [IDX_W-1:0] bank_index(input int j);
        int v;
        if (j < BANK_A_CNT) v = WIN_A_LO + 4 + 2 * j;
        else                v = WIN_B_LO + 2 * (j - BANK_A_CNT);
        return IDX_W'(v);
    endfunction

    // Saturate a written attenuation code: bit 5 forces the maximum code.
    function automatic logic [CODE_W-1:0] sat_code(input logic [CODE_W-1:0] w);
        return w[CODE_W-1] ? {1'b0, {(CODE_W-1){1'b1}}} : w;
    endfunction
endpackage

// File: rtl/codec_idx_decode.sv
// Module: index decoder. Maps a bus index to the identification word,
// the volume word or a bank slot. Odd and unmapped indices hit nothing.
// Assumes the bank slot map is given by codec_regs_pkg::bank_index.
module codec_idx_decode
    import codec_regs_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    output logic              is_ident,
    output logic              is_vol,
    output logic              bank_hit,
    output logic [SLOT_W-1:0] bank_slot,
    output logic              any_hit
);
    // Fixed-index compares for the two special words.
    always_comb begin
        is_ident = (idx == IDX_IDENT);
        is_vol   = (idx == IDX_VOL);
    end

    // Search the slot map for an exact match.
    always_comb begin
        bank_hit  = 1'b0;
        bank_slot = '0;
        for (int j = 0; j < BANK_CNT; j++) begin
            if (idx == bank_index(j)) begin
                bank_hit  = 1'b1;
                bank_slot = SLOT_W'(j);
            end
        end
    end

    // Any mapped register.
    always_comb any_hit = is_ident | is_vol | bank_hit;
endmodule

// File: rtl/codec_vol_reg.sv
// Module: master volume word. Holds mute and two saturating attenuation codes.
// Assumes wr_sel is one cycle per write. A soft reset and a write never
// coincide, because they decode from different indices.
module codec_vol_reg
    import codec_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_sel,
    input  logic              wr_mute,
    input  logic [CODE_W-1:0] wr_left,
    input  logic [CODE_W-1:0] wr_right,
    output logic [DATA_W-1:0] vol_word,
    output logic              mute,
    output logic [CODE_W-1:0] atten_l,
    output logic [CODE_W-1:0] atten_r
);
    // Store the fields, clamping each code on write.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            mute    <= VOL_DEFAULT[15];
            atten_l <= '0;
            atten_r <= '0;
        end else if (wr_sel) begin
            mute    <= wr_mute;
            atten_l <= sat_code(wr_left);
            atten_r <= sat_code(wr_right);
        end
    end

    // Pack the read-back word; the spare bits read as zero.
    always_comb vol_word = {mute, 1'b0, atten_l, 2'b00, atten_r};

    AST_LEFT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && wr_left[CODE_W-1]) |=> (atten_l == 6'h1F)); // R5
    AST_RIGHT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && wr_right[CODE_W-1]) |=> (atten_r == 6'h1F)); // R5
    AST_LEFT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !wr_left[CODE_W-1]) |=> (atten_l == $past(wr_left))); // R6
    AST_VOL_SOFT_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mute && atten_l == '0 && atten_r == '0)); // R3
endmodule

// File: rtl/codec_gen_bank.sv
// Module: bank of plain 16-bit read/write words, one per mapped slot.
// Assumes wr_sel is one cycle per write. Every slot clears to zero on
// either reset.
module codec_gen_bank
    import codec_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_sel,
    input  logic [SLOT_W-1:0] slot,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] mem [BANK_CNT];

    for (genvar g = 0; g < BANK_CNT; g++) begin : g_slot
        // One storage word, written when its slot is selected.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst)                 mem[g] <= '0;
            else if (wr_sel && slot == SLOT_W'(g))  mem[g] <= wr_data;
        end

        AST_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_sel && slot == SLOT_W'(g)) |=> (mem[g] == $past(wr_data))); // R7
        AST_BANK_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            soft_rst |=> (mem[g] == '0)); // R3
    end

    // Select the addressed word for the read path.
    always_comb begin
        rd_word = '0;
        for (int j = 0; j < BANK_CNT; j++)
            if (slot == SLOT_W'(j)) rd_word = mem[j];
    end
endmodule

// File: rtl/codec_ctrl_regs.sv
// Module: top of the codec control register file. Decodes the index,
// routes writes, raises a soft reset on a write to index 00h and registers
// the read word. Assumes one access per strobe cycle.
module codec_ctrl_regs
    import codec_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              mute_o,
    output logic [CODE_W-1:0] atten_l_o,
    output logic [CODE_W-1:0] atten_r_o
);
    logic              is_ident, is_vol, bank_hit, any_hit;
    logic [SLOT_W-1:0] bank_slot;
    logic              soft_rst;
    logic [DATA_W-1:0] vol_word, bank_word;

    codec_idx_decode u_dec (
        .idx      (reg_idx),
        .is_ident (is_ident),
        .is_vol   (is_vol),
        .bank_hit (bank_hit),
        .bank_slot(bank_slot),
        .any_hit  (any_hit)
    );

    // A write of any data to the identification index resets both windows.
    always_comb soft_rst = wr_en && is_ident;

    codec_vol_reg u_vol (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .wr_sel  (wr_en && is_vol),
        .wr_mute (wr_data[15]),
        .wr_left (wr_data[13:8]),
        .wr_right(wr_data[5:0]),
        .vol_word(vol_word),
        .mute    (mute_o),
        .atten_l (atten_l_o),
        .atten_r (atten_r_o)
    );

    codec_gen_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .wr_sel  (wr_en && bank_hit),
        .slot    (bank_slot),
        .wr_data (wr_data),
        .rd_word (bank_word)
    );

    // Registered read path; uses the stored values from before any same-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n)          rd_data <= '0;
        else if (rd_en) begin
            if (is_ident)      rd_data <= IDENT_WORD;
            else if (is_vol)   rd_data <= vol_word;
            else if (bank_hit) rd_data <= bank_word;
            else               rd_data <= '0;
        end
    end

    AST_IDENT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_idx == IDX_IDENT) |=> (rd_data == 16'h25AD)); // R2
    AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !any_hit) |=> (rd_data == '0)); // R9
    AST_ODD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_idx[0]) |=> (rd_data == '0)); // R8
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R10
    AST_VOL_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && is_vol) |=> (rd_data[14] == 1'b0 && rd_data[7:6] == 2'b00)); // R4
endmodule

// File: tb/codec_ctrl_regs_test.sv
`timescale 1ns/1ps
// Directed bench for codec_ctrl_regs: one task per scenario.
module codec_ctrl_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  reg_idx = '0;
    logic [15:0] wr_data = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        mute_o;
    logic [5:0]  atten_l_o, atten_r_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    codec_ctrl_regs uut (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
        .mute_o(mute_o), .atten_l_o(atten_l_o), .atten_r_o(atten_r_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Expected saturation, written from the requirement.
    function automatic logic [5:0] exp_code(input logic [5:0] w);
        return (w >= 6'd32) ? 6'd31 : w;
    endfunction

    function automatic logic [15:0] exp_vol(input logic [15:0] w);
        return {w[15], 1'b0, exp_code(w[13:8]), 2'b00, exp_code(w[5:0])};
    endfunction

    task automatic wr(input logic [6:0] i, input logic [15:0] d);
        @(negedge clk);
        reg_idx = i; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] i, output logic [15:0] d);
        @(negedge clk);
        reg_idx = i; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 mute_o", {15'd0, mute_o}, 16'd1);
        check("R1 atten_l", {10'd0, atten_l_o}, 16'd0);
        check("R1 atten_r", {10'd0, atten_r_o}, 16'd0);
        rd(7'h02, v); check("R1 vol word", v, 16'h8000);
        rd(7'h04, v); check("R1 bank 04", v, 16'h0000);
        rd(7'h7A, v); check("R1 bank 7A", v, 16'h0000);
    endtask

    task automatic t_ident();
        logic [15:0] v;
        rd(7'h00, v);
        check("R2 ident", v, 16'h25AD);
        check("R2 enh id", {11'd0, v[14:10]}, 16'h0009);
    endtask

    task automatic t_volume();
        logic [15:0] v;
        logic [15:0] pats [6] = '{16'h0A03, 16'h40C5, 16'hA523, 16'h3F3F, 16'h1F1F, 16'h2000};
        foreach (pats[k]) begin
            wr(7'h02, pats[k]);
            check("R4 mute_o", {15'd0, mute_o}, {15'd0, pats[k][15]});
            check("R5 R6 atten_l", {10'd0, atten_l_o}, {10'd0, exp_code(pats[k][13:8])});
            check("R5 R6 atten_r", {10'd0, atten_r_o}, {10'd0, exp_code(pats[k][5:0])});
            rd(7'h02, v);
            check("R4 R5 vol readback", v, exp_vol(pats[k]));
        end
    endtask

    task automatic t_bank();
        logic [15:0] v;
        wr(7'h04, 16'hA5A5); wr(7'h3A, 16'h1234);
        wr(7'h5A, 16'hBEEF); wr(7'h7A, 16'h0F0F);
        rd(7'h04, v); check("R7 bank 04", v, 16'hA5A5);
        rd(7'h3A, v); check("R7 bank 3A", v, 16'h1234);
        rd(7'h5A, v); check("R7 bank 5A", v, 16'hBEEF);
        rd(7'h7A, v); check("R7 bank 7A", v, 16'h0F0F);
    endtask

    task automatic t_odd();
        logic [15:0] v;
        wr(7'h05, 16'hFFFF); wr(7'h03, 16'h1F1F);
        rd(7'h04, v); check("R8 odd write left 04", v, 16'hA5A5);
        rd(7'h02, v); check("R8 odd write left vol", v, exp_vol(16'h2000));
        rd(7'h05, v); check("R8 odd read", v, 16'h0000);
    endtask

    task automatic t_hole();
        logic [15:0] v;
        wr(7'h3C, 16'h7777); wr(7'h58, 16'h8888); wr(7'h7C, 16'h9999);
        rd(7'h3C, v); check("R9 hole 3C", v, 16'h0000);
        rd(7'h58, v); check("R9 hole 58", v, 16'h0000);
        rd(7'h7E, v); check("R9 hole 7E", v, 16'h0000);
        rd(7'h3A, v); check("R9 neighbour 3A", v, 16'h1234);
        rd(7'h5A, v); check("R9 neighbour 5A", v, 16'hBEEF);
    endtask

    task automatic t_latency();
        logic [15:0] v;
        rd(7'h3A, v); check("R10 read", v, 16'h1234);
        @(negedge clk); reg_idx = 7'h5A;
        @(negedge clk); @(negedge clk);
        check("R10 hold without strobe", rd_data, 16'h1234);
    endtask

    task automatic t_same_cycle();
        logic [15:0] v;
        @(negedge clk);
        reg_idx = 7'h04; wr_data = 16'h5A5A; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R11 old value", rd_data, 16'hA5A5);
        rd(7'h04, v); check("R11 new value", v, 16'h5A5A);
    endtask

    task automatic t_soft_reset();
        logic [15:0] v;
        wr(7'h02, 16'h0A0A);
        wr(7'h00, 16'h1234);
        check("R3 mute_o after soft reset", {15'd0, mute_o}, 16'd1);
        check("R3 atten_l after soft reset", {10'd0, atten_l_o}, 16'd0);
        rd(7'h00, v); check("R3 ident unchanged", v, 16'h25AD);
        rd(7'h02, v); check("R3 vol default", v, 16'h8000);
        rd(7'h04, v); check("R3 bank 04 cleared", v, 16'h0000);
        rd(7'h3A, v); check("R3 bank 3A cleared", v, 16'h0000);
        rd(7'h5A, v); check("R3 bank 5A cleared", v, 16'h0000);
        rd(7'h7A, v); check("R3 bank 7A cleared", v, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ident();
        t_volume();
        t_bank();
        t_odd();
        t_hole();
        t_latency();
        t_same_cycle();
        t_soft_reset();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule